// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and erases one block per request. A request is a single-cycle `start_i` pulse carrying a block number. The sequencer holds chip enable low for the whole job. It first sends the status command and reads one status byte. If that byte reports the device as write-protected, the job ends at once and no erase command is sent.

Otherwise the sequencer sends the erase setup command 60h, two row-address bytes and the confirm command D0h. It then sends the status command once and polls with repeated read cycles until the ready bit comes up or a poll budget runs out. The outcome is reported with a one-cycle `done_o` pulse and three error flags. The flags stay valid until the next request is accepted.

Every bus byte is driven by a shared cycle engine whose setup, strobe-low and hold lengths are parameters, counted in clock cycles. The block-number width, the page-field width and the poll budget are also parameters.

Top module: `nes_erase_seq`

## Requirements
- R1: During and right after reset, and after a reset applied in the middle of a job, chip enable, write enable and read enable are high, command latch, address latch, data output enable and `done_o` are low.
- R2: Each job first writes command 70h with command latch high and then performs one read cycle. If status bit 7 of that byte is 0 (protected), the job ends with `err_wp_o` set, and no other byte is written.
- R3: For a writable device the next writes are: 60h with command latch, then two bytes with address latch, then D0h with command latch. The row address is the block number shifted left by PAGE_W zero bits, sent low byte first. With the defaults the first address byte is {blk[1:0], 6'b0} and the second is blk[9:2].
- R4: In every write cycle, command latch, address latch and the data byte are driven T_SETUP cycles before write enable falls. Write enable stays low for T_WL cycles. All three are held for T_WH cycles after write enable rises. Command latch and address latch are never high together.
- R5: After D0h, exactly one 70h command is written. The sequencer then repeats read cycles, without writing again, until a byte with bit 6 = 1 (ready) is seen. Each read holds read enable low for T_RL cycles and samples the bus in the last of them. Write enable and read enable are never low together.
- R6: When the ready byte arrives, status bit 0 selects the result: 1 sets `err_fail_o` and 0 leaves all flags clear (pass). Status bits 1 to 5 have no effect. At most one flag is set.
- R7: If TMO_POLLS poll reads in a row all show busy, the job ends with `err_tmo_o` set and no further read is made. A ready bit on read number TMO_POLLS still counts as completion.
- R8: `done_o` is a single-cycle pulse, issued once per job, in the same cycle that chip enable returns high. The flags keep their values after the pulse. Chip enable is low whenever write enable or read enable is low.
- R9: A `start_i` pulse while a job is running is ignored: the running job keeps its block number and finishes with a single `done_o`.
- R10: The data output enable is high only during write cycles and never while read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to erase a block |
| blk_i | input | BLK_W | Block number, sampled with `start_i` |
| done_o | output | 1 | One-cycle completion pulse |
| err_fail_o | output | 1 | Device reported erase failure |
| err_wp_o | output | 1 | Device is write-protected, no erase sent |
| err_tmo_o | output | 1 | Ready never appeared within the poll budget |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write enable, active low |
| nand_re_n_o | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Byte driven onto the bus |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Byte read from the bus |

## Verification
The bench builds the block with a 20-read poll budget. This makes the edge of the timeout reachable in a few hundred cycles: 19 busy reads must still pass and 20 must time out. It uses unequal strobe lengths: setup 1, write-low 2, hold 2 and read-low 3. With these, any mix-up between the setup, pulse and hold counters changes a measured width. The behavioural device in the bench drives a fixed junk pattern on the unused status bits, and the block number is kept at its default width of 10 bits. Together these let both address bytes, and the status masking, be checked against values computed from the block number alone.

// File: rtl/nes_pkg.sv
package nes_pkg;

  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;

  localparam int STAT_PF_BIT   = 0;
  localparam int STAT_RDY_BIT  = 6;
  localparam int STAT_OPEN_BIT = 7;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSU,
    PH_WLO,
    PH_WHI,
    PH_RLO,
    PH_RHI
  } nes_phase_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE_CMD,
    S_PRE_RD,
    S_SETUP,
    S_ADDR0,
    S_ADDR1,
    S_CONFIRM,
    S_STAT_CMD,
    S_POLL
  } nes_state_e;

  typedef enum logic [1:0] {
    RES_PASS,
    RES_FAIL,
    RES_WP,
    RES_TMO
  } nes_res_e;

  typedef struct packed {
    logic open;
    logic ready;
    logic fail;
  } nes_stat_t;

endpackage

// File: rtl/nes_bus_cycle.sv
module nes_bus_cycle
  import nes_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_WL    = 3,
  parameter int T_WH    = 2,
  parameter int T_RL    = 3,
  parameter int T_RH    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       rd,
  input  logic [7:0] wr_byte,
  input  logic       wr_cle,
  input  logic       wr_ale,
  input  logic [7:0] dq_i,
  output logic       we_n,
  output logic       re_n,
  output logic       cle,
  output logic       ale,
  output logic       oe,
  output logic [7:0] dq_o,
  output logic [7:0] rd_byte,
  output logic       op_done
);

  localparam int M1 = (T_SETUP > T_WL) ? T_SETUP : T_WL;
  localparam int M2 = (M1 > T_WH) ? M1 : T_WH;
  localparam int M3 = (M2 > T_RL) ? M2 : T_RL;
  localparam int M4 = (M3 > T_RH) ? M3 : T_RH;
  localparam int CW = (M4 < 2) ? 1 : $clog2(M4);

  nes_phase_e     ph, ph_n;
  logic [CW-1:0]  cnt, cnt_n;

  always_comb begin
    ph_n  = ph;
    cnt_n = cnt;
    case (ph)
      PH_IDLE: begin
        if (go) begin
          if (rd) begin
            ph_n  = PH_RLO;
            cnt_n = CW'(T_RL - 1);
          end else begin
            ph_n  = PH_WSU;
            cnt_n = CW'(T_SETUP - 1);
          end
        end
      end
      PH_WSU: begin
        if (cnt == '0) begin
          ph_n  = PH_WLO;
          cnt_n = CW'(T_WL - 1);
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      PH_WLO: begin
        if (cnt == '0) begin
          ph_n  = PH_WHI;
          cnt_n = CW'(T_WH - 1);
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      PH_WHI: begin
        if (cnt == '0) ph_n = PH_IDLE;
        else           cnt_n = cnt - CW'(1);
      end
      PH_RLO: begin
        if (cnt == '0) begin
          ph_n  = PH_RHI;
          cnt_n = CW'(T_RH - 1);
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      PH_RHI: begin
        if (cnt == '0) ph_n = PH_IDLE;
        else           cnt_n = cnt - CW'(1);
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      cle     <= 1'b0;
      ale     <= 1'b0;
      oe      <= 1'b0;
      dq_o    <= '0;
      rd_byte <= '0;
      op_done <= 1'b0;
    end else begin
      ph      <= ph_n;
      cnt     <= cnt_n;
      we_n    <= (ph_n != PH_WLO);
      re_n    <= (ph_n != PH_RLO);
      oe      <= (ph_n == PH_WSU) || (ph_n == PH_WLO) || (ph_n == PH_WHI);
      op_done <= (ph != PH_IDLE) && (ph_n == PH_IDLE);
      if (ph == PH_IDLE && go && !rd) begin
        dq_o <= wr_byte;
        cle  <= wr_cle;
        ale  <= wr_ale;
      end else if (ph_n == PH_IDLE) begin
        cle <= 1'b0;
        ale <= 1'b0;
      end
      if (ph == PH_RLO && cnt == '0) rd_byte <= dq_i;
    end
  end

endmodule

// File: rtl/nes_row_fmt.sv
module nes_row_fmt #(
  parameter int BLK_W  = 10,
  parameter int PAGE_W = 6
) (
  input  logic [BLK_W-1:0] blk_i,
  output logic [7:0]       lo_o,
  output logic [7:0]       hi_o
);

  localparam int ROW_W = BLK_W + PAGE_W;

  logic [ROW_W-1:0] row;
  logic [15:0]      row16;

  assign row = {blk_i, {PAGE_W{1'b0}}};

  generate
    if (ROW_W < 16) begin : g_pad
      assign row16 = {{(16 - ROW_W){1'b0}}, row};
    end else begin : g_cut
      assign row16 = row[15:0];
      if (ROW_W > 16) begin : g_rest
        logic unused_row_hi;
        assign unused_row_hi = ^row[ROW_W-1:16];
      end
    end
  endgenerate

  assign lo_o = row16[7:0];
  assign hi_o = row16[15:8];

endmodule

// File: rtl/nes_stat_dec.sv
module nes_stat_dec
  import nes_pkg::*;
(
  input  logic [7:0] stat_i,
  output nes_stat_t  st_o
);

  logic unused_stat;
  assign unused_stat = ^stat_i;

  assign st_o.open  = stat_i[STAT_OPEN_BIT];
  assign st_o.ready = stat_i[STAT_RDY_BIT];
  assign st_o.fail  = stat_i[STAT_PF_BIT];

endmodule

// File: rtl/nes_erase_seq.sv
module nes_erase_seq
  import nes_pkg::*;
#(
  parameter int BLK_W     = 10,
  parameter int PAGE_W    = 6,
  parameter int T_SETUP   = 2,
  parameter int T_WL      = 3,
  parameter int T_WH      = 2,
  parameter int T_RL      = 3,
  parameter int T_RH      = 2,
  parameter int TMO_POLLS = 1000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             done_o,
  output logic             err_fail_o,
  output logic             err_wp_o,
  output logic             err_tmo_o,
  output logic             nand_ce_n_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_n_o,
  output logic             nand_re_n_o,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe_o,
  input  logic [7:0]       nand_dq_i
);

  localparam int PW = $clog2(TMO_POLLS + 1);

  nes_state_e       st, st_n;
  nes_res_e         res_n;
  logic             fin;
  logic             pending;
  logic [BLK_W-1:0] blk_q;
  logic [PW-1:0]    poll_cnt;

  logic             go, rd, op_cle, op_ale, op_done;
  logic [7:0]       op_byte, rd_byte, row_lo, row_hi;
  nes_stat_t        stat;

  nes_row_fmt #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_row (
    .blk_i (blk_q),
    .lo_o  (row_lo),
    .hi_o  (row_hi)
  );

  nes_stat_dec u_dec (
    .stat_i (rd_byte),
    .st_o   (stat)
  );

  nes_bus_cycle #(
    .T_SETUP (T_SETUP),
    .T_WL    (T_WL),
    .T_WH    (T_WH),
    .T_RL    (T_RL),
    .T_RH    (T_RH)
  ) u_bus (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .rd      (rd),
    .wr_byte (op_byte),
    .wr_cle  (op_cle),
    .wr_ale  (op_ale),
    .dq_i    (nand_dq_i),
    .we_n    (nand_we_n_o),
    .re_n    (nand_re_n_o),
    .cle     (nand_cle_o),
    .ale     (nand_ale_o),
    .oe      (nand_dq_oe_o),
    .dq_o    (nand_dq_o),
    .rd_byte (rd_byte),
    .op_done (op_done)
  );

  // Bus operation requested by the current step
  always_comb begin
    go      = (st != S_IDLE) && !pending;
    rd      = 1'b0;
    op_byte = '0;
    op_cle  = 1'b0;
    op_ale  = 1'b0;
    case (st)
      S_PRE_CMD, S_STAT_CMD: begin
        op_byte = CMD_STATUS;
        op_cle  = 1'b1;
      end
      S_PRE_RD, S_POLL: rd = 1'b1;
      S_SETUP: begin
        op_byte = CMD_ERASE_SETUP;
        op_cle  = 1'b1;
      end
      S_ADDR0: begin
        op_byte = row_lo;
        op_ale  = 1'b1;
      end
      S_ADDR1: begin
        op_byte = row_hi;
        op_ale  = 1'b1;
      end
      S_CONFIRM: begin
        op_byte = CMD_ERASE_GO;
        op_cle  = 1'b1;
      end
      default: go = 1'b0;
    endcase
  end

  // Step sequencing and result decision
  always_comb begin
    st_n  = st;
    fin   = 1'b0;
    res_n = RES_PASS;
    case (st)
      S_IDLE:     if (start_i) st_n = S_PRE_CMD;
      S_PRE_CMD:  if (op_done) st_n = S_PRE_RD;
      S_PRE_RD: begin
        if (op_done) begin
          if (!stat.open) begin
            fin   = 1'b1;
            res_n = RES_WP;
          end else begin
            st_n = S_SETUP;
          end
        end
      end
      S_SETUP:    if (op_done) st_n = S_ADDR0;
      S_ADDR0:    if (op_done) st_n = S_ADDR1;
      S_ADDR1:    if (op_done) st_n = S_CONFIRM;
      S_CONFIRM:  if (op_done) st_n = S_STAT_CMD;
      S_STAT_CMD: if (op_done) st_n = S_POLL;
      S_POLL: begin
        if (op_done) begin
          if (stat.ready) begin
            fin   = 1'b1;
            res_n = stat.fail ? RES_FAIL : RES_PASS;
          end else if (poll_cnt == PW'(TMO_POLLS - 1)) begin
            fin   = 1'b1;
            res_n = RES_TMO;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (fin) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      pending     <= 1'b0;
      blk_q       <= '0;
      poll_cnt    <= '0;
      done_o      <= 1'b0;
      err_fail_o  <= 1'b0;
      err_wp_o    <= 1'b0;
      err_tmo_o   <= 1'b0;
      nand_ce_n_o <= 1'b1;
    end else begin
      st     <= st_n;
      done_o <= fin;
      if (op_done)  pending <= 1'b0;
      else if (go)  pending <= 1'b1;
      if (st == S_IDLE && start_i) begin
        blk_q       <= blk_i;
        poll_cnt    <= '0;
        nand_ce_n_o <= 1'b0;
        err_fail_o  <= 1'b0;
        err_wp_o    <= 1'b0;
        err_tmo_o   <= 1'b0;
      end
      if (st == S_POLL && op_done && !fin) poll_cnt <= poll_cnt + PW'(1);
      if (fin) begin
        nand_ce_n_o <= 1'b1;
        err_fail_o  <= (res_n == RES_FAIL);
        err_wp_o    <= (res_n == RES_WP);
        err_tmo_o   <= (res_n == RES_TMO);
      end
    end
  end

endmodule

// File: rtl/nes_erase_chk.sv
module nes_erase_chk (
  input logic       clk,
  input logic       rst,
  input logic       done_i,
  input logic       fail_i,
  input logic       wp_i,
  input logic       tmo_i,
  input logic       ce_n_i,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_n_i,
  input logic       re_n_i,
  input logic       oe_i,
  input logic [7:0] dq_i
);

  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(cle_i && ale_i));

  assert_hold_under_we_R4: assert property (@(posedge clk) disable iff (rst)
    (!we_n_i && $past(!we_n_i)) |-> ($stable(dq_i) && $stable(cle_i) && $stable(ale_i)));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n_i && !re_n_i));

  assert_single_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !done_i);

  assert_ce_released_R8: assert property (@(posedge clk) disable iff (rst)
    done_i |-> ce_n_i);

  assert_ce_covers_R8: assert property (@(posedge clk) disable iff (rst)
    (!we_n_i || !re_n_i) |-> !ce_n_i);

  assert_one_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fail_i, wp_i, tmo_i}));

  assert_oe_not_read_R10: assert property (@(posedge clk) disable iff (rst)
    oe_i |-> re_n_i);

  assert_oe_with_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (cle_i || ale_i) |-> oe_i);

endmodule

bind nes_erase_seq nes_erase_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .done_i (done_o),
  .fail_i (err_fail_o),
  .wp_i   (err_wp_o),
  .tmo_i  (err_tmo_o),
  .ce_n_i (nand_ce_n_o),
  .cle_i  (nand_cle_o),
  .ale_i  (nand_ale_o),
  .we_n_i (nand_we_n_o),
  .re_n_i (nand_re_n_o),
  .oe_i   (nand_dq_oe_o),
  .dq_i   (nand_dq_o)
);

// File: tb/sim_nes_erase_seq.sv
module sim_nes_erase_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TS  = 1;
  localparam int TWL = 2;
  localparam int TWH = 2;
  localparam int TRL = 3;
  localparam int TRH = 1;
  localparam int TMO = 20;
  localparam int NV  = 7;

  // fields: [23:14] block, [13] protected, [12] fail, [11:4] busy reads, [1:0] expected (0 pass,1 fail,2 wp,3 timeout)
  localparam logic [23:0] VECS [NV] = '{
    {10'h3FF, 1'b0, 1'b0, 8'd3,  2'b00, 2'd0},
    {10'h001, 1'b0, 1'b1, 8'd0,  2'b00, 2'd1},
    {10'h2A5, 1'b1, 1'b0, 8'd0,  2'b00, 2'd2},
    {10'h155, 1'b0, 1'b0, 8'd19, 2'b00, 2'd0},
    {10'h200, 1'b0, 1'b0, 8'd20, 2'b00, 2'd3},
    {10'h000, 1'b0, 1'b1, 8'd5,  2'b00, 2'd1},
    {10'h0F0, 1'b1, 1'b1, 8'd4,  2'b00, 2'd2}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [9:0] blk = '0;
  logic       done, e_fail, e_wp, e_tmo;
  logic       ce_n, cle, ale, we_n, re_n, oe;
  logic [7:0] dq_o, dq_i;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nes_erase_seq #(
    .BLK_W(10), .PAGE_W(6), .T_SETUP(TS), .T_WL(TWL), .T_WH(TWH),
    .T_RL(TRL), .T_RH(TRH), .TMO_POLLS(TMO)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start), .blk_i(blk),
    .done_o(done), .err_fail_o(e_fail), .err_wp_o(e_wp), .err_tmo_o(e_tmo),
    .nand_ce_n_o(ce_n), .nand_cle_o(cle), .nand_ale_o(ale),
    .nand_we_n_o(we_n), .nand_re_n_o(re_n), .nand_dq_o(dq_o),
    .nand_dq_oe_o(oe), .nand_dq_i(dq_i)
  );

  // Behavioural device
  logic       cfg_prot = 1'b0;
  logic       cfg_fail = 1'b0;
  int         cfg_busy = 0;
  int         busy_left = 0;
  bit         erased = 0;
  int         poll_reads = 0;
  int         lg_n = 0;
  logic [7:0] lg_byte [16];
  logic [1:0] lg_kind [16];
  logic       ready_m;

  assign ready_m = (busy_left == 0);
  assign dq_i = {~cfg_prot, ready_m, 5'b10101, ready_m ? cfg_fail : 1'b1};

  always @(posedge we_n) begin
    if (lg_n < 16) begin
      lg_byte[lg_n] = dq_o;
      lg_kind[lg_n] = {cle, ale};
    end
    lg_n++;
    if (cle && dq_o == 8'hD0) begin
      erased    = 1;
      busy_left = cfg_busy;
    end
  end

  always @(posedge re_n) begin
    if (erased) begin
      poll_reads++;
      if (busy_left > 0) busy_left--;
    end
  end

  // Strobe width and done monitors
  int su = 0, lo = 0, hi = 0, rlo = 0, tbad = 0, oebad = 0, done_cnt = 0;
  bit seen_lo = 0;

  always @(negedge clk) begin
    if (rst) begin
      su = 0; lo = 0; hi = 0; rlo = 0; seen_lo = 0;
    end else begin
      if (oe) begin
        if (!we_n) begin
          seen_lo = 1;
          lo++;
        end else if (!seen_lo) su++;
        else hi++;
      end else if (su + lo + hi > 0) begin
        if (su != TS || lo != TWL || hi != TWH) tbad++;
        su = 0; lo = 0; hi = 0; seen_lo = 0;
      end
      if (!re_n) begin
        rlo++;
        if (oe) oebad++;
      end else if (rlo > 0) begin
        if (rlo != TRL) tbad++;
        rlo = 0;
      end
      if (done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    lg_n = 0; erased = 0; poll_reads = 0; busy_left = 0; done_cnt = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done, "R8", "done pulse seen", done, 1);
  endtask

  task automatic launch(input logic [9:0] b, input bit prot, input bit fl, input int busy);
    @(negedge clk);
    cfg_prot = prot; cfg_fail = fl; cfg_busy = busy;
    clear_model();
    blk = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_erase_log(input logic [9:0] b);
    logic [7:0] eb [6];
    logic [1:0] ek [6];
    eb = '{8'h70, 8'h60, {b[1:0], 6'b0}, b[9:2], 8'hD0, 8'h70};
    ek = '{2'b10, 2'b10, 2'b01, 2'b01, 2'b10, 2'b10};
    check(lg_n == 6, "R5", "write count", lg_n, 6);
    for (int i = 0; i < 6; i++) begin
      check(lg_byte[i] == eb[i], "R3", "written byte", lg_byte[i], eb[i]);
      check(lg_kind[i] == ek[i], "R3", "latch kind", lg_kind[i], ek[i]);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ce_n && we_n && re_n, "R1", "strobes high in reset", {ce_n, we_n, re_n}, 7);
    check(!cle && !ale && !oe && !done, "R1", "latches low in reset", {cle, ale, oe, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ce_n && !oe, "R1", "idle after reset", {ce_n, oe}, 2);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [9:0] vb;
      int vbusy, vexp, epolls;
      vb = VECS[v][23:14];
      vbusy = int'(VECS[v][11:4]);
      vexp = int'(VECS[v][1:0]);
      launch(vb, VECS[v][13], VECS[v][12], vbusy);
      wait_done();
      check(ce_n, "R8", "ce released with done", ce_n, 1);
      check(e_fail == (vexp == 1), "R6", "fail flag", e_fail, vexp == 1);
      check(e_wp == (vexp == 2), "R2", "protect flag", e_wp, vexp == 2);
      check(e_tmo == (vexp == 3), "R7", "timeout flag", e_tmo, vexp == 3);
      if (vexp == 2) begin
        check(lg_n == 1 && lg_byte[0] == 8'h70 && lg_kind[0] == 2'b10,
              "R2", "only status command written", lg_n, 1);
        check(!erased, "R2", "no erase issued", erased, 0);
      end else begin
        check_erase_log(vb);
        epolls = (vbusy >= TMO) ? TMO : vbusy + 1;
        check(poll_reads == epolls, "R7", "poll reads", poll_reads, epolls);
      end
      @(negedge clk);
      check(!done, "R8", "done one cycle", done, 0);
      check(done_cnt == 1, "R8", "done count", done_cnt, 1);
      check(e_fail == (vexp == 1) && e_tmo == (vexp == 3) && e_wp == (vexp == 2),
            "R8", "flags held", {e_tmo, e_wp, e_fail}, vexp);
    end

    // R9: start while busy is ignored
    launch(10'h3C1, 1'b0, 1'b0, 2);
    repeat (10) @(negedge clk);
    blk = 10'h00E;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    @(negedge clk);
    check_erase_log(10'h3C1);
    check(done_cnt == 1, "R9", "single done for ignored start", done_cnt, 1);
    repeat (20) @(negedge clk);
    check(done_cnt == 1 && ce_n, "R9", "no second job", done_cnt, 1);

    // R1: reset in the middle of a job
    launch(10'h111, 1'b0, 1'b0, 6);
    repeat (12) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ce_n && we_n && re_n && !cle && !ale && !oe && !done, "R1", "mid-job reset",
          {ce_n, we_n, re_n, cle, ale, oe, done}, 7'b1110000);
    rst = 1'b0;
    launch(10'h0AB, 1'b0, 1'b1, 1);
    wait_done();
    check(e_fail && !e_wp && !e_tmo, "R6", "job after reset", {e_tmo, e_wp, e_fail}, 1);

    // R4, R5, R10: measured strobe widths and output enable
    repeat (3) @(negedge clk);
    check(tbad == 0, "R4", "strobe width errors", tbad, 0);
    check(oebad == 0, "R10", "output enable during read", oebad, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer", 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule